// File: doc/BRIEF.md
# Device Interrupt Status Latch with Guarded Clear

This block collects level-sensitive interrupt lines from devices behind a low-pin-count host bridge and holds them in a 32-bit status word. The status word also holds an internal error flag, which is raised when a bus access is never answered. Software reads the word, masks it, and acknowledges bits by writing ones. An acknowledge is refused for any device whose line is still high, so a device that is still asserting cannot lose its request. An optional mode drops a device's status bit on its own when the line falls, but only on systems strapped for routed serial interrupts.

The block presents a masked active-interrupt vector for the routing logic that follows it. Device bits reach that vector only while the serial-interrupt enable is set. The block also decodes the start-frame length field of its control register into a clock count. Registers are reached through a single-cycle port: writes take effect on the clock edge and reads are combinational.

Top module: `hostirq_stat_top`

## Requirements
- R1: Device input n (0..NUM_DEV-1) owns status bit 31-n, so device 0 is bit 31 and device 16 is bit 15. Status bits that are neither device bits nor bit 0 always read as zero.
- R2: A low-to-high change on a device input sets its status bit and its level-tracking bit on the next clock edge. The level word reads at address 3 in the status layout.
- R3: Writing the status register (address 2) clears every device bit that is set in the write data and whose tracked level is low. A bit whose tracked level is high keeps its value.
- R4: When control bit 23 (auto-clear) is set and routed_mode_i is high, a high-to-low change on a device input clears its status bit on the same edge that clears its tracking bit.
- R5: When control bit 23 is clear or routed_mode_i is low, a falling input leaves its status bit unchanged.
- R6: active_o equals status AND mask (mask at address 1, same layout as status). While control bit 31 (serial-interrupt enable) is clear, all device bits of active_o are zero.
- R7: A cycle with bus_noresp_i high sets status bit 0. Writing 1 to status bit 0 clears it. This bit is not gated by the enable.
- R8: start_clks_o decodes control bits 25:24: 00 gives 4, 01 gives 6, and 10 or 11 gives 8.
- R9: After reset, control, mask, status and the level word are all zero, and active_o is zero.
- R10: If a rising input and a status write clearing the same bit fall in the same cycle, the bit ends up set. A no-response error in the same cycle as a clear of bit 0 also leaves bit 0 set.
- R11: The control register (address 0) and the mask register read back the last 32-bit value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_irq_i | input | NUM_DEV | Device interrupt levels, index n is device n |
| bus_noresp_i | input | 1 | Pulse for a bus access that got no response |
| routed_mode_i | input | 1 | Strap that permits auto-clear |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | 0 control, 1 mask, 2 status, 3 level word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| active_o | output | 32 | Masked, enable-gated active vector |
| start_clks_o | output | 4 | Start-frame length in clocks |

## Verification
Directed patterns separate the cases that matter. An acknowledge is tried while the line is still high and again after it drops. A falling line is tried under each combination of auto-clear bit and strap. A rise is made to coincide with an acknowledge of the same bit, and device bits are checked with the enable toggled while the error bit stays visible. Random stretches then toggle device lines sparsely, write random values to all registers, and pulse the error input. These stretches expose ordering slips between the tracked level and the clear, and errors in the bit reversal between device index and status position.

// File: rtl/hostirq_pkg.sv
package hostirq_pkg;
  localparam int unsigned REG_W         = 32;
  localparam int unsigned CTRL_EN_BIT   = 31;
  localparam int unsigned CTRL_AUTO_BIT = 23;
  localparam int unsigned CTRL_LEN_LO   = 24;
  localparam int unsigned ERR_BIT       = 0;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_MASK = 2'd1,
    A_STAT = 2'd2,
    A_LVL  = 2'd3
  } reg_addr_e;

  function automatic logic [3:0] start_clks(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd4;
      2'b01:   return 4'd6;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/hostirq_track.sv
module hostirq_track #(
  parameter int unsigned N = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] lvl_q_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign lvl_q_o = lvl_q;
  assign rise_o  = lvl_i & ~lvl_q;
  assign fall_o  = ~lvl_i & lvl_q;
endmodule

// File: rtl/hostirq_regs.sv
module hostirq_regs
  import hostirq_pkg::*;
#(
  parameter int unsigned N = 17,
  parameter int unsigned W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         noresp_i,
  input  logic         routed_i,
  input  logic [N-1:0] lvl_q_i,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] fall_i,
  output logic [W-1:0] ctrl_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] ctrl_q, mask_q;
  logic [N-1:0] dev_stat;
  logic         err_q;
  logic [N-1:0] wdev, clr_dev, auto_dev;
  logic [W-1:0] stat_word, lvl_word;
  logic         stat_we, auto_on;

  // device n <-> word bit W-1-n
  always_comb begin
    stat_word = '0;
    lvl_word  = '0;
    for (int n = 0; n < N; n++) begin
      stat_word[W-1-n] = dev_stat[n];
      lvl_word[W-1-n]  = lvl_q_i[n];
      wdev[n]          = wdata_i[W-1-n];
    end
    stat_word[ERR_BIT] = err_q;
  end

  assign stat_we  = we_i && (addr_i == A_STAT);
  assign auto_on  = routed_i && ctrl_q[CTRL_AUTO_BIT];
  assign clr_dev  = stat_we ? (wdev & ~lvl_q_i) : '0;
  assign auto_dev = auto_on ? fall_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      mask_q   <= '0;
      dev_stat <= '0;
      err_q    <= 1'b0;
    end else begin
      if (we_i && addr_i == A_CTRL) ctrl_q <= wdata_i;
      if (we_i && addr_i == A_MASK) mask_q <= wdata_i;
      dev_stat <= (dev_stat & ~clr_dev & ~auto_dev) | rise_i;  // set wins
      err_q    <= (err_q & ~(stat_we & wdata_i[ERR_BIT])) | noresp_i;
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_MASK:  rdata_o = mask_q;
      A_STAT:  rdata_o = stat_word;
      default: rdata_o = lvl_word;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign mask_o = mask_q;
  assign stat_o = stat_word;

  p_rise_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i != '0) |=> ((dev_stat & $past(rise_i)) == $past(rise_i)));

  p_hold_while_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we && fall_i == '0) |=>
      ((dev_stat & $past(lvl_q_i & dev_stat)) == $past(lvl_q_i & dev_stat)));

  p_auto_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_on && fall_i != '0) |=> ((dev_stat & $past(fall_i)) == '0));

  p_no_auto_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_on && !stat_we && fall_i != '0) |=>
      ((dev_stat & $past(fall_i)) == ($past(dev_stat) & $past(fall_i))));

  p_noresp_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noresp_i |=> err_q);
endmodule

// File: rtl/hostirq_stat_top.sv
module hostirq_stat_top
  import hostirq_pkg::*;
#(
  parameter int unsigned NUM_DEV = 17
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DEV-1:0] dev_irq_i,
  input  logic               bus_noresp_i,
  input  logic               routed_mode_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic [31:0]        active_o,
  output logic [3:0]         start_clks_o
);
  localparam int unsigned W = REG_W;

  logic [NUM_DEV-1:0] lvl_q, rise, fall;
  logic [W-1:0]       ctrl, mask, stat, dev_field;

  hostirq_track #(.N(NUM_DEV)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (dev_irq_i),
    .lvl_q_o (lvl_q),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  hostirq_regs #(.N(NUM_DEV), .W(W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .noresp_i (bus_noresp_i),
    .routed_i (routed_mode_i),
    .lvl_q_i  (lvl_q),
    .rise_i   (rise),
    .fall_i   (fall),
    .ctrl_o   (ctrl),
    .mask_o   (mask),
    .stat_o   (stat),
    .rdata_o  (reg_rdata_o)
  );

  always_comb begin
    dev_field = '0;
    for (int n = 0; n < NUM_DEV; n++) dev_field[W-1-n] = 1'b1;
  end

  assign active_o     = stat & mask & ~(ctrl[CTRL_EN_BIT] ? '0 : dev_field);
  assign start_clks_o = start_clks(ctrl[CTRL_LEN_LO+1:CTRL_LEN_LO]);

  p_active_subset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((active_o & ~(stat & mask)) == '0));

  p_gate_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl[CTRL_EN_BIT] |-> ((active_o & dev_field) == '0));
endmodule

// File: tb/tb_hostirq_stat_top.sv
module tb_hostirq_stat_top;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 17;

  logic clk = 0, rst_n = 0;
  logic [ND-1:0] dev = '0;
  logic noresp = 0, routed = 0, we = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata, active;
  logic [3:0] sclk;

  int checks = 0, fails = 0;

  logic [ND-1:0] m_inp = '0, m_dev = '0;
  logic m_err = 0;
  logic [31:0] m_ctrl = 0, m_mask = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostirq_stat_top #(.NUM_DEV(ND)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dev_irq_i(dev), .bus_noresp_i(noresp),
    .routed_mode_i(routed), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .active_o(active),
    .start_clks_o(sclk));

  function automatic logic [31:0] to_word(input logic [ND-1:0] v);
    logic [31:0] w = '0;
    for (int n = 0; n < ND; n++) w[31-n] = v[n];
    return w;
  endfunction

  function automatic logic [ND-1:0] from_word(input logic [31:0] w);
    logic [ND-1:0] v;
    for (int n = 0; n < ND; n++) v[n] = w[31-n];
    return v;
  endfunction

  function automatic logic [31:0] m_stat();
    logic [31:0] s = to_word(m_dev);
    s[0] = m_err;
    return s;
  endfunction

  function automatic logic [31:0] m_active();
    logic [31:0] a = m_stat() & m_mask;
    if (!m_ctrl[31]) a = a & ~to_word('1);
    return a;
  endfunction

  function automatic logic [3:0] m_sclk();
    case (m_ctrl[25:24])
      2'b00: return 4'd4;
      2'b01: return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // inputs already driven (negedge); clock once, update model, check at negedge
  task automatic step(input string tag);
    logic [ND-1:0] rise, fall, clr, aut;
    logic sw;
    @(posedge clk);
    sw   = we && addr == 2'd2;
    rise = dev & ~m_inp;
    fall = ~dev & m_inp;
    clr  = sw ? (from_word(wdata) & ~m_inp) : '0;
    aut  = (routed && m_ctrl[23]) ? fall : '0;
    m_dev = (m_dev & ~clr & ~aut) | rise;
    m_err = (m_err & ~(sw & wdata[0])) | noresp;
    if (we && addr == 2'd0) m_ctrl = wdata;
    if (we && addr == 2'd1) m_mask = wdata;
    m_inp = dev;
    @(negedge clk);
    we = 0; noresp = 0;
    chk({tag, " active R6"}, active, m_active());
    chk({tag, " start R8"}, {28'd0, sclk}, {28'd0, m_sclk()});
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    we = 1; addr = a; wdata = d;
    step(tag);
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic rd_model(input string tag);
    rd(2'd0, m_ctrl, {tag, " ctrl R11"});
    rd(2'd1, m_mask, {tag, " mask R11"});
    rd(2'd2, m_stat(), {tag, " stat R1"});
    rd(2'd3, to_word(m_inp), {tag, " lvl R2"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 active", active, 32'h0);
    chk("R9 start", {28'd0, sclk}, 32'd4);
    rd(2'd0, 0, "R9 ctrl"); rd(2'd1, 0, "R9 mask");
    rd(2'd2, 0, "R9 stat"); rd(2'd3, 0, "R9 lvl");

    wr(2'd0, 32'h8000_0000, "en");
    wr(2'd1, 32'hFFFF_FFFF, "mask");
    rd(2'd1, 32'hFFFF_FFFF, "R11 mask");
    rd(2'd0, 32'h8000_0000, "R11 ctrl");

    // R1/R2 mapping and latch
    dev[0] = 1; step("R2 rise0");
    chk("R1 dev0 bit31", active, 32'h8000_0000);
    rd(2'd3, 32'h8000_0000, "R2 lvl dev0");
    dev[16] = 1; step("R2 rise16");
    chk("R1 dev16 bit15", active, 32'h8000_8000);

    // R3 refused while high, accepted after fall
    wr(2'd2, 32'hFFFF_FFFF, "R3 clr high");
    rd(2'd2, 32'h8000_8000, "R3 held");
    dev[0] = 0; step("R5 fall no auto");
    rd(2'd2, 32'h8000_8000, "R5 kept");
    wr(2'd2, 32'h8000_0000, "R3 clr low");
    rd(2'd2, 32'h0000_8000, "R3 cleared");

    // R6 gating and partial mask
    wr(2'd0, 32'h0, "R6 en off");
    chk("R6 gated", active, 32'h0);
    rd(2'd2, 32'h0000_8000, "R6 stat kept");
    // R7 noresp visible without enable
    noresp = 1; step("R7 noresp");
    chk("R7 err bit0", active, 32'h0000_0001);
    wr(2'd1, 32'h0000_8000, "R6 mask part");
    wr(2'd0, 32'h8000_0000, "R6 en on");
    chk("R6 masked", active, 32'h0000_8000);
    wr(2'd2, 32'h0000_0001, "R7 clr err");
    rd(2'd2, 32'h0000_8000, "R7 cleared");
    wr(2'd1, 32'hFFFF_FFFF, "mask all");

    // R4 auto-clear
    wr(2'd0, 32'h8080_0000, "auto on");
    routed = 1;
    dev[3] = 1; step("R4 rise3");
    rd(2'd2, 32'h1000_8000, "R4 set3");
    dev[3] = 0; step("R4 fall3");
    rd(2'd2, 32'h0000_8000, "R4 auto cleared");
    // R5 strap low
    routed = 0;
    dev[3] = 1; step("R5 rise3");
    dev[3] = 0; step("R5 fall3");
    rd(2'd2, 32'h1000_8000, "R5 strap low kept");
    // R5 ctrl bit low, strap high
    routed = 1;
    wr(2'd0, 32'h8000_0000, "auto off");
    wr(2'd2, 32'h1000_0000, "clr3");
    dev[3] = 1; step("R5 rise3b");
    dev[3] = 0; step("R5 fall3b");
    rd(2'd2, 32'h1000_8000, "R5 ctrl off kept");

    // R10 set wins
    dev[5] = 1; we = 1; addr = 2'd2; wdata = 32'h0400_0001; noresp = 1;
    step("R10 race");
    rd(2'd2, 32'h1400_8001, "R10 set wins");

    // R8 length decode
    wr(2'd0, 32'h8100_0000, "len1");
    chk("R8 six", {28'd0, sclk}, 32'd6);
    wr(2'd0, 32'h8200_0000, "len2");
    chk("R8 eight", {28'd0, sclk}, 32'd8);
    wr(2'd0, 32'h8300_0000, "len3");
    chk("R8 eight3", {28'd0, sclk}, 32'd8);
    rd_model("directed");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      for (int n = 0; n < ND; n++)
        if ($urandom_range(15) == 0) dev[n] = ~dev[n];
      noresp = ($urandom_range(19) == 0);
      if ($urandom_range(29) == 0) routed = ~routed;
      if ($urandom_range(3) == 0) begin
        we = 1;
        addr = 2'($urandom_range(2));
        wdata = $urandom();
        if (addr == 2'd0 && $urandom_range(1) == 0) wdata[31] = 1'b1;
      end
      step("rand");
      if (i % 7 == 0) rd_model("rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule